// File: doc/BRIEF.md
# Chained-Buffer Transmit DMA Channel

This block is a one-way DMA channel that feeds a word-oriented consumer, for example a hash engine's data input, from memory. Software describes up to two buffers as pointer/count pairs: a current pair and a next pair. The channel reads one 32-bit word at a time from the current pointer through a request/response memory port. It offers the word to the consumer with a valid/ready handshake. When the consumer takes the word, the pointer moves on by one word and the count drops by one. When the current count runs out and a next count is waiting, the next pair drops into the current pair in the same clock edge. Two buffers therefore stream back to back without software help.

The expected software sequence is: disable the channel, load the current pointer and count, load the next pointer and count (pointer before count), then enable. Two level flags leave the block for the consumer's interrupt status, where they sit at bits 1 and 2. `end_of_buf` reports that the current buffer is finished. `all_empty` reports that no buffer is left.

The fetch engine is a four-state machine:
- ST_IDLE goes to ST_ISSUE ("launch") when the channel is on, the current count is nonzero and the consumer is ready.
- ST_ISSUE goes to ST_AWAIT ("granted") when the memory accepts the read.
- ST_AWAIT goes to ST_OFFER ("filled") on the response.
- ST_OFFER goes back to ST_IDLE ("delivered") when the consumer takes the word.

Top module: `pdma_tx_chan`

## Requirements
- R1: Register offsets, in bytes:
  - 0x108 is the current pointer and 0x10C the current count.
  - 0x118 is the next pointer and 0x11C the next count.
  - 0x120 is the control register; it is write-only and reads as zero.
  - 0x124 is the status register, with bit 8 set while transmission is enabled.
  - Reads of the pointer and count registers return the stored values, and counts are in 32-bit words.
- R2: A control write with bit 8 set turns the channel on and one with bit 9 set turns it off. If both are set, off wins. Other control bits have no effect.
- R3: After reset:
  - both pointers and both counts are zero and the channel is off;
  - `mem_req_valid` and `cons_valid` are low;
  - `end_of_buf` and `all_empty` are high.
- R4: Each word is read from the current pointer and delivered in address order. On every consumer acceptance the current pointer rises by 4 and the current count falls by 1.
- R5: On the edge where the current count reaches zero while the next count is nonzero:
  - the current pointer and count take the next pointer and count;
  - the next count becomes zero;
  - the next pointer keeps its value.
- R6: A next count of zero means no chained buffer: the channel stops after the current buffer with no extra transfer.
- R7: `end_of_buf` is high exactly when the current count is zero. `all_empty` is high exactly when both counts are zero.
- R8: Ready and hold rules:
  - No read request is raised in a cycle where `cons_ready` is low.
  - A raised request holds its address until accepted.
  - An offered word holds its data until accepted.
- R9: Turning the channel off stops new fetches. A word already requested is still delivered. The pointer and count stay intact, and turning the channel back on resumes from where it stopped.
- R10: A read is launched only while the channel is on and the current count is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset (read and write) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cons_valid | output | 1 | Word offered to the consumer |
| cons_ready | input | 1 | Consumer takes the word |
| cons_data | output | 32 | Offered word |
| end_of_buf | output | 1 | Current count is zero |
| all_empty | output | 1 | Both counts are zero |

## Verification
The assertions on stepping and reloading assume that software leaves the pointer and count registers alone while a word is moving. The address-hold assertion assumes the same for the current pointer while a request is pending. The bench honours this: it writes buffer registers only while the channel is off or idle, and during a transfer it writes only the control register. The memory model answers exactly one cycle after accepting a request and never sends an unrequested response. The consumer and memory ready patterns vary between always, alternating and two-of-three, so every handshake wait is exercised.

// File: rtl/pdma_tx_pkg.sv
package pdma_tx_pkg;

    // Register byte offsets (9-bit window)
    localparam logic [8:0] OFS_CUR_PTR = 9'h108;
    localparam logic [8:0] OFS_CUR_CNT = 9'h10C;
    localparam logic [8:0] OFS_NXT_PTR = 9'h118;
    localparam logic [8:0] OFS_NXT_CNT = 9'h11C;
    localparam logic [8:0] OFS_CTRL    = 9'h120;
    localparam logic [8:0] OFS_STAT    = 9'h124;

    // Control / status bit positions
    localparam int BIT_TX_ON   = 8;
    localparam int BIT_TX_OFF  = 9;
    localparam int BIT_TX_STAT = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_AWAIT,
        ST_OFFER
    } fetch_state_e;

endpackage

// File: rtl/pdma_buf_regs.sv
module pdma_buf_regs
    import pdma_tx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    input  logic           word_taken,
    output logic [AW-1:0]  cur_ptr,
    output logic [CW-1:0]  cur_cnt,
    output logic [AW-1:0]  nxt_ptr,
    output logic [CW-1:0]  nxt_cnt,
    output logic           end_of_buf,
    output logic           all_empty
);

    localparam int STEP = DW / 8;

    logic          wr_cp, wr_cc, wr_np, wr_nc, any_wr;
    logic [AW-1:0] ptr_step;
    logic [CW-1:0] cnt_step;
    logic          do_reload;

    assign wr_cp  = reg_we && (reg_addr == RAW'(OFS_CUR_PTR));
    assign wr_cc  = reg_we && (reg_addr == RAW'(OFS_CUR_CNT));
    assign wr_np  = reg_we && (reg_addr == RAW'(OFS_NXT_PTR));
    assign wr_nc  = reg_we && (reg_addr == RAW'(OFS_NXT_CNT));
    assign any_wr = wr_cp | wr_cc | wr_np | wr_nc;

    // Effective current pair after this cycle's acceptance, then reload test
    always_comb begin
        ptr_step  = word_taken ? cur_ptr + AW'(STEP) : cur_ptr;
        cnt_step  = word_taken ? cur_cnt - 1'b1      : cur_cnt;
        do_reload = (cnt_step == '0) && (nxt_cnt != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_ptr <= '0;
            cur_cnt <= '0;
            nxt_ptr <= '0;
            nxt_cnt <= '0;
        end else begin
            if (do_reload) begin
                cur_ptr <= nxt_ptr;
                cur_cnt <= nxt_cnt;
                nxt_cnt <= '0;
            end else begin
                cur_ptr <= ptr_step;
                cur_cnt <= cnt_step;
            end
            // Software writes take priority register by register
            if (wr_cp) cur_ptr <= reg_wdata[AW-1:0];
            if (wr_cc) cur_cnt <= reg_wdata[CW-1:0];
            if (wr_np) nxt_ptr <= reg_wdata[AW-1:0];
            if (wr_nc) nxt_cnt <= reg_wdata[CW-1:0];
        end
    end

    assign end_of_buf = (cur_cnt == '0);
    assign all_empty  = end_of_buf && (nxt_cnt == '0);

    AST_STEP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_taken && cur_cnt > 1 && !any_wr) |=>
        (cur_cnt == $past(cur_cnt) - 1'b1 && cur_ptr == $past(cur_ptr) + AW'(STEP))); // R4

    AST_RELOAD_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (word_taken && cur_cnt == 1 && nxt_cnt != '0 && !any_wr) |=>
        (cur_ptr == $past(nxt_ptr) && cur_cnt == $past(nxt_cnt) && nxt_cnt == '0)); // R5

    AST_STOP_WITHOUT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (word_taken && cur_cnt == 1 && nxt_cnt == '0 && !any_wr) |=>
        (all_empty && cur_ptr == $past(cur_ptr) + AW'(STEP))); // R6

endmodule

// File: rtl/pdma_ctrl_regs.sv
module pdma_ctrl_regs
    import pdma_tx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [1:0]     ctl_bits,   // [0] turn on, [1] turn off
    input  logic [AW-1:0]  cur_ptr,
    input  logic [CW-1:0]  cur_cnt,
    input  logic [AW-1:0]  nxt_ptr,
    input  logic [CW-1:0]  nxt_cnt,
    output logic           tx_on,
    output logic [31:0]    reg_rdata
);

    logic wr_ctl;
    assign wr_ctl = reg_we && (reg_addr == RAW'(OFS_CTRL));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_on <= 1'b0;
        end else if (wr_ctl) begin
            if (ctl_bits[1])      tx_on <= 1'b0;
            else if (ctl_bits[0]) tx_on <= 1'b1;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RAW'(OFS_CUR_PTR): reg_rdata = 32'(cur_ptr);
            RAW'(OFS_CUR_CNT): reg_rdata = 32'(cur_cnt);
            RAW'(OFS_NXT_PTR): reg_rdata = 32'(nxt_ptr);
            RAW'(OFS_NXT_CNT): reg_rdata = 32'(nxt_cnt);
            RAW'(OFS_STAT):    reg_rdata[BIT_TX_STAT] = tx_on;
            default:           reg_rdata = '0;
        endcase
    end

    AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_bits[1]) |=> !tx_on); // R2

    AST_ON_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && ctl_bits[0] && !ctl_bits[1]) |=> tx_on); // R2

endmodule

// File: rtl/pdma_fetch_fsm.sv
module pdma_fetch_fsm
    import pdma_tx_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_on,
    input  logic [AW-1:0] cur_ptr,
    input  logic [CW-1:0] cur_cnt,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          cons_valid,
    input  logic          cons_ready,
    output logic [DW-1:0] cons_data,
    output logic          word_taken
);

    fetch_state_e state_q, state_d;
    logic [DW-1:0] data_q;

    // State register and word holding register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_AWAIT && mem_rsp_valid) data_q <= mem_rsp_data;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_on && cur_cnt != '0 && cons_ready) state_d = ST_ISSUE; // launch
            ST_ISSUE: if (mem_req_ready) state_d = ST_AWAIT;                         // granted
            ST_AWAIT: if (mem_rsp_valid) state_d = ST_OFFER;                         // filled
            ST_OFFER: if (cons_ready)    state_d = ST_IDLE;                          // delivered
        endcase
    end

    // Outputs
    always_comb begin
        mem_req_valid = (state_q == ST_ISSUE);
        mem_req_addr  = cur_ptr;
        cons_valid    = (state_q == ST_OFFER);
        cons_data     = data_q;
        word_taken    = cons_valid && cons_ready;
    end

    AST_NO_REQ_WITHOUT_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(cons_ready)); // R8

    AST_FETCH_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(tx_on && cur_cnt != '0)); // R10

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R8

    AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (cons_valid && !cons_ready) |=> (cons_valid && $stable(cons_data))); // R8

endmodule

// File: rtl/pdma_tx_chan.sv
module pdma_tx_chan
    import pdma_tx_pkg::*;
#(
    parameter int AW  = 32,
    parameter int DW  = 32,
    parameter int CW  = 16,
    parameter int RAW = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           reg_we,
    input  logic [RAW-1:0] reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rsp_data,
    output logic           cons_valid,
    input  logic           cons_ready,
    output logic [DW-1:0]  cons_data,
    output logic           end_of_buf,
    output logic           all_empty
);

    logic [AW-1:0] cur_ptr, nxt_ptr;
    logic [CW-1:0] cur_cnt, nxt_cnt;
    logic          tx_on;
    logic          word_taken;

    pdma_buf_regs #(.AW(AW), .DW(DW), .CW(CW), .RAW(RAW)) u_bufs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .word_taken (word_taken),
        .cur_ptr    (cur_ptr),
        .cur_cnt    (cur_cnt),
        .nxt_ptr    (nxt_ptr),
        .nxt_cnt    (nxt_cnt),
        .end_of_buf (end_of_buf),
        .all_empty  (all_empty)
    );

    pdma_ctrl_regs #(.AW(AW), .CW(CW), .RAW(RAW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .ctl_bits  ({reg_wdata[BIT_TX_OFF], reg_wdata[BIT_TX_ON]}),
        .cur_ptr   (cur_ptr),
        .cur_cnt   (cur_cnt),
        .nxt_ptr   (nxt_ptr),
        .nxt_cnt   (nxt_cnt),
        .tx_on     (tx_on),
        .reg_rdata (reg_rdata)
    );

    pdma_fetch_fsm #(.AW(AW), .DW(DW), .CW(CW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .tx_on         (tx_on),
        .cur_ptr       (cur_ptr),
        .cur_cnt       (cur_cnt),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .cons_valid    (cons_valid),
        .cons_ready    (cons_ready),
        .cons_data     (cons_data),
        .word_taken    (word_taken)
    );

    AST_FLAGS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        all_empty |-> end_of_buf); // R7

endmodule

// File: tb/pdma_tx_chan_tb.sv
module pdma_tx_chan_tb;

    localparam logic [8:0] A_CP = 9'h108, A_CC = 9'h10C, A_NP = 9'h118,
                           A_NC = 9'h11C, A_CTL = 9'h120, A_ST = 9'h124;

    logic        clk, rst_n;
    logic        reg_we;
    logic [8:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        mem_req_valid, mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        cons_valid, cons_ready;
    logic [31:0] cons_data;
    logic        end_of_buf, all_empty;

    pdma_tx_chan u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cons_valid(cons_valid),
        .cons_ready(cons_ready), .cons_data(cons_data),
        .end_of_buf(end_of_buf), .all_empty(all_empty)
    );

    int n_chk = 0, n_bad = 0;
    int cons_mode = 0, mem_mode = 0;
    int rx_cnt = 0;
    bit saw_req = 0;
    logic [31:0] rx_data [0:63];

    function automatic logic [31:0] wordfn(input logic [31:0] a);
        return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin clk = 0; forever #4 clk = ~clk; end

    // Consumer model
    initial begin
        int cyc = 0;
        cons_ready = 0;
        forever begin
            @(negedge clk);
            cyc++;
            case (cons_mode)
                0: cons_ready = 1'b1;
                1: cons_ready = cyc[0];
                2: cons_ready = 1'b0;
                default: cons_ready = (cyc % 3) != 0;
            endcase
            if (rst_n && cons_valid && cons_ready) begin
                if (rx_cnt < 64) rx_data[rx_cnt] = cons_data;
                rx_cnt++;
            end
            if (mem_req_valid) saw_req = 1;
        end
    end

    // Memory model: answers one cycle after accepting
    initial begin
        int mc = 0;
        bit pend = 0;
        logic [31:0] paddr = '0;
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = '0;
        forever begin
            @(negedge clk);
            mc++;
            mem_rsp_valid = pend;
            mem_rsp_data  = pend ? wordfn(paddr) : 32'h0;
            pend = 0;
            case (mem_mode)
                0: mem_req_ready = 1'b1;
                1: mem_req_ready = mc[0];
                default: mem_req_ready = (mc % 3) != 1;
            endcase
            if (rst_n && mem_req_valid && mem_req_ready) begin
                pend = 1; paddr = mem_req_addr;
            end
        end
    end

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_wdata = '0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_rx(input int target);
        for (int t = 0; t < 600 && rx_cnt < target; t++) begin @(negedge clk); #2; end
        repeat (10) @(negedge clk);
    endtask

    task automatic load(input logic [31:0] p, input int n, input logic [31:0] q, input int m);
        wr(A_CTL, 32'h200);
        wr(A_CP, p); wr(A_CC, n); wr(A_NP, q); wr(A_NC, m);
        @(negedge clk);
    endtask

    task automatic run_chain(input logic [31:0] p, input int n, input logic [31:0] q, input int m);
        logic [31:0] v, ea;
        load(p, n, q, m);
        rd(A_CP, v); chk(v === ((n == 0 && m > 0) ? q : p), "R1 cur ptr readback", v, (n == 0 && m > 0) ? q : p);
        rd(A_CC, v); chk(v === ((n == 0) ? m : n), "R1 cur count readback", v, (n == 0) ? m : n);
        rd(A_NP, v); chk(v === q, "R1 next ptr readback", v, q);
        rd(A_NC, v); chk(v === ((n == 0) ? 0 : m), "R5 next count after load", v, (n == 0) ? 0 : m);
        chk(end_of_buf === (n + m == 0), "R7 end flag loaded", end_of_buf, n + m == 0);
        chk(all_empty === (n + m == 0), "R7 empty flag loaded", all_empty, n + m == 0);
        rx_cnt = 0;
        wr(A_CTL, 32'h100);
        wait_rx(n + m);
        chk(rx_cnt == n + m, "R6 word total", rx_cnt, n + m);
        for (int i = 0; i < n + m; i++) begin
            ea = (i < n) ? p + 4 * i : q + 4 * (i - n);
            chk(rx_data[i] === wordfn(ea), (i < n) ? "R4 word data" : "R5 chained word data", rx_data[i], wordfn(ea));
        end
        ea = (m > 0) ? q + 4 * m : p + 4 * n;
        rd(A_CP, v); chk(v === ea, "R5 final cur ptr", v, ea);
        rd(A_CC, v); chk(v === 0, "R4 final cur count", v, 0);
        rd(A_NC, v); chk(v === 0, "R5 next count cleared", v, 0);
        chk(end_of_buf === 1'b1, "R7 end flag drained", end_of_buf, 1);
        chk(all_empty === 1'b1, "R7 empty flag drained", all_empty, 1);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        int k, idx;
        rst_n = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R3 reset state
        rd(A_CP, v); chk(v === 0, "R3 cur ptr reset", v, 0);
        rd(A_CC, v); chk(v === 0, "R3 cur count reset", v, 0);
        rd(A_NP, v); chk(v === 0, "R3 next ptr reset", v, 0);
        rd(A_NC, v); chk(v === 0, "R3 next count reset", v, 0);
        rd(A_ST, v); chk(v === 0, "R3 status reset", v, 0);
        chk(cons_valid === 1'b0, "R3 cons_valid reset", cons_valid, 0);
        chk(mem_req_valid === 1'b0, "R3 mem_req_valid reset", mem_req_valid, 0);
        chk(end_of_buf === 1'b1 && all_empty === 1'b1, "R3 flags reset", {end_of_buf, all_empty}, 2'b11);

        // R2 control semantics, R1 control reads zero
        wr(A_CTL, 32'h100); rd(A_ST, v); chk(v === 32'h100, "R2 enable", v, 32'h100);
        rd(A_CTL, v); chk(v === 0, "R1 control reads zero", v, 0);
        wr(A_CTL, 32'h0FF); rd(A_ST, v); chk(v === 32'h100, "R2 other bits ignored", v, 32'h100);
        wr(A_CTL, 32'h300); rd(A_ST, v); chk(v === 0, "R2 off wins from on", v, 0);
        wr(A_CTL, 32'h300); rd(A_ST, v); chk(v === 0, "R2 off wins from off", v, 0);
        wr(A_CTL, 32'h200); rd(A_ST, v); chk(v === 0, "R2 disable", v, 0);

        // R10 no fetch while off
        load(32'h0000_4000, 2, 32'h0, 0);
        saw_req = 0; rx_cnt = 0;
        repeat (20) @(negedge clk);
        chk(saw_req == 0, "R10 no request while off", saw_req, 0);
        rd(A_CC, v); chk(v === 2, "R10 count untouched while off", v, 2);

        // R8 no read while consumer not ready
        cons_mode = 2; saw_req = 0;
        wr(A_CTL, 32'h100);
        repeat (20) @(negedge clk);
        chk(saw_req == 0, "R8 no request while cons_ready low", saw_req, 0);
        chk(rx_cnt == 0, "R8 nothing delivered", rx_cnt, 0);
        cons_mode = 0;
        wait_rx(2);
        chk(rx_cnt == 2, "R8 resumes when ready", rx_cnt, 2);

        // Sweep of chained configurations and handshake patterns
        idx = 0;
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 4; m++) begin
                cons_mode = (idx % 3 == 2) ? 3 : idx % 3;
                mem_mode  = (idx / 3) % 3;
                run_chain(32'h0001_0000 + 32'h100 * idx, n, 32'h0802_0000 + 32'h40 * idx, m);
                idx++;
            end
        end

        // R9 disable mid-stream keeps position, re-enable resumes
        cons_mode = 0; mem_mode = 0;
        load(32'h0000_3000, 6, 32'h0, 0);
        rx_cnt = 0;
        wr(A_CTL, 32'h100);
        for (int t = 0; t < 200 && rx_cnt < 2; t++) begin @(negedge clk); #2; end
        wr(A_CTL, 32'h200);
        repeat (20) @(negedge clk);
        k = rx_cnt;
        chk(k >= 2 && k <= 4, "R9 fetch stops after disable", k, 3);
        rd(A_CC, v); chk(v === 6 - k, "R9 count kept", v, 6 - k);
        rd(A_CP, v); chk(v === 32'h3000 + 4 * k, "R9 pointer kept", v, 32'h3000 + 4 * k);
        repeat (20) @(negedge clk);
        chk(rx_cnt == k, "R9 stays stopped", rx_cnt, k);
        wr(A_CTL, 32'h100);
        wait_rx(6);
        chk(rx_cnt == 6, "R9 resume total", rx_cnt, 6);
        for (int i = 0; i < 6; i++)
            chk(rx_data[i] === wordfn(32'h3000 + 4 * i), "R9 resumed word data", rx_data[i], wordfn(32'h3000 + 4 * i));

        summary();
        $finish;
    end

endmodule